// File: doc/BRIEF.md
# Software-Managed Fully Associative Translation Buffer

This block holds a set of virtual-to-physical page translations that system software loads and inspects explicitly. There is no hardware table walk. Software uses a command port for four operations: store a translation into a named slot, store one into a slot that the hardware picks, read a slot back, and search all slots for a virtual page. A separate translation port takes a 32-bit virtual address with a load/store flag. One cycle later it returns the physical address, the no-cache attribute, and a fault code that reports a missing translation, an invalid entry, or a store to a write-protected page.

Pages are 4 KB. Each slot keeps a 20-bit virtual page, a 6-bit address-space tag, a 20-bit physical page and four flag bits. The tag and the global flag are only stored and read back. A slot is retired by parking it on a virtual page in the upper half of the address space. Those addresses skip the lookup, so a parked slot can never translate, but a search still finds it.

Top module: `soft_tlb`

## Requirements
- R1: While reset is held, and after it, `rsp_valid` and `xl_done` are 0. After reset, slot i holds high word ((0x80000+i) << 12) and low word 0.
- R2: Command codes are: 00 writes `cmd_hi`/`cmd_lo` into slot `cmd_index`, 01 writes into the hardware-chosen slot, 10 reads a slot and 11 probes. A read raises `rsp_valid` one cycle later. `rsp_hi` then carries the virtual page in bits 31:12 and the tag in bits 11:6, with every other bit 0. `rsp_lo` carries the physical page in 31:12, no-cache in 11, dirty in 10, valid in 9 and global in 8, with every other bit 0.
- R3: A probe compares `cmd_hi[31:12]` with every slot, whatever that slot's valid bit says. One cycle later `rsp_probe` holds the lowest matching slot index, zero-extended, or 0xFFFFFFFF when no slot matches.
- R4: The hardware-chosen slot comes from a counter. It is 63 on the first clock after reset, goes down by one on every clock, and wraps from 0 to 63.
- R5: A translation that matches a slot whose valid bit is set, and that is not a store to a slot with dirty clear, gives `xl_fault`=00 and `xl_paddr` = {physical page, `xl_vaddr[11:0]`}, with `xl_nocache` equal to the slot's no-cache bit.
- R6: A translation that matches no slot gives `xl_fault`=01, with `xl_paddr`=0 and `xl_nocache`=0.
- R7: A match on a slot whose valid bit is clear gives `xl_fault`=10, for loads and for stores alike, with `xl_paddr`=0.
- R8: A store (`xl_write`=1) that matches a valid slot with dirty clear gives `xl_fault`=11 and `xl_paddr`=0. A load through the same slot translates normally.
- R9: When `xl_vaddr[31]` is 1, no lookup takes place: `xl_paddr` equals `xl_vaddr`, `xl_fault`=00 and `xl_nocache`=0.
- R10: The address-space tag and the global bit have no effect on probing or on translation.
- R11: A translation, read or probe sees the slot contents from before any write issued in the same cycle. Results appear on the clock edge after the request, with `xl_done` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (R2) |
| cmd_index | input | 6 | Slot for indexed write and read |
| cmd_hi | input | 32 | High word for write and probe |
| cmd_lo | input | 32 | Low word for write |
| rsp_valid | output | 1 | Read or probe result valid |
| rsp_hi | output | 32 | High word of last read |
| rsp_lo | output | 32 | Low word of last read |
| rsp_probe | output | 32 | Last probe result |
| xl_valid | input | 1 | Translation request |
| xl_vaddr | input | 32 | Virtual address |
| xl_write | input | 1 | 1 for store access |
| xl_done | output | 1 | Translation result valid |
| xl_paddr | output | 32 | Physical address |
| xl_nocache | output | 1 | No-cache attribute |
| xl_fault | output | 2 | 00 ok, 01 miss, 10 invalid, 11 modify |

## Verification
Two things can happen in the same cycle: a command-port write into a slot, and a translation of the page that the write installs. The bench issues both on one edge and expects a miss, because the lookup must see the slot as it was before the write. On the next cycle it repeats the translation and expects a hit. Random-slot writes run alongside the free-running down-counter. The bench times one pair of back-to-back random writes so that they fall at counter values 0 and 63, then probes to confirm the wrap.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
   localparam int WORD_W     = 32;
   localparam int PG_OFF_W   = 12;
   localparam int VPN_W      = 20;
   localparam int ASID_W     = 6;
   localparam int ASID_LSB   = 6;
   localparam int NC_BIT     = 11;
   localparam int DIRTY_BIT  = 10;
   localparam int VALID_BIT  = 9;
   localparam int GLOBAL_BIT = 8;
   localparam logic [VPN_W-1:0] PARK_VPN_BASE = 20'h80000;

   typedef enum logic [1:0] {
      OP_WR_IDX = 2'b00,
      OP_WR_RND = 2'b01,
      OP_RD     = 2'b10,
      OP_PROBE  = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      XF_NONE    = 2'b00,
      XF_MISS    = 2'b01,
      XF_INVALID = 2'b10,
      XF_MODIFY  = 2'b11
   } xfault_e;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [VPN_W-1:0]  ppn;
      logic              nc;
      logic              wen;
      logic              vld;
      logic              glb;
   } slot_t;
endpackage

// File: rtl/stlb_victim.sv
module stlb_victim #(
   parameter  int ENTRIES = 64,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] slot
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            slot <= TOP;
      else if (slot == '0)   slot <= TOP;
      else                   slot <= slot - 1'b1;
   end

   // R4
   victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot != '0) |=> (slot == $past(slot) - 1'b1));
   // R4
   victim_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == '0) |=> (slot == TOP));
endmodule

// File: rtl/stlb_prienc.sv
module stlb_prienc #(
   parameter  int N        = 64,
   parameter  bit LOW_WINS = 1'b1,
   localparam int W        = $clog2(N)
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   assign any = |req;

   generate
      if (LOW_WINS) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (req[i]) idx = W'(i);
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (req[i]) idx = W'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/stlb_entries.sv
module stlb_entries
   import stlb_pkg::*;
#(
   parameter  int ENTRIES = 64,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   wr_idx,
   input  slot_t              wr_slot,
   input  logic [IDX_W-1:0]   rd_idx,
   output slot_t              rd_slot,
   input  logic [IDX_W-1:0]   xl_idx,
   output slot_t              xl_slot,
   input  logic [VPN_W-1:0]   key_probe,
   input  logic [VPN_W-1:0]   key_xl,
   output logic [ENTRIES-1:0] hit_probe,
   output logic [ENTRIES-1:0] hit_xl
);
   slot_t mem [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            mem[i]     <= '0;
            mem[i].vpn <= PARK_VPN_BASE + VPN_W'(i);
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++)
            if (we && wr_idx == IDX_W'(i)) mem[i] <= wr_slot;
      end
   end

   assign rd_slot = mem[rd_idx];
   assign xl_slot = mem[xl_idx];

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         assign hit_probe[g] = (mem[g].vpn == key_probe);
         assign hit_xl[g]    = (mem[g].vpn == key_xl);
      end
   endgenerate

   // R2
   slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(wr_idx)] == $past(wr_slot)));
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
   import stlb_pkg::*;
#(
   parameter  int ENTRIES        = 64,
   parameter  bit PROBE_LOW_WINS = 1'b1,
   localparam int IDX_W          = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [IDX_W-1:0] cmd_index,
   input  logic [31:0]      cmd_hi,
   input  logic [31:0]      cmd_lo,
   output logic             rsp_valid,
   output logic [31:0]      rsp_hi,
   output logic [31:0]      rsp_lo,
   output logic [31:0]      rsp_probe,
   input  logic             xl_valid,
   input  logic [31:0]      xl_vaddr,
   input  logic             xl_write,
   output logic             xl_done,
   output logic [31:0]      xl_paddr,
   output logic             xl_nocache,
   output logic [1:0]       xl_fault
);
   generate
      if (ENTRIES < 2 || ENTRIES > (1 << (VPN_W - 1))) begin : g_bad_entries
         $error("soft_tlb: ENTRIES out of range");
      end
      if (IDX_W > WORD_W - 1) begin : g_bad_idx
         $error("soft_tlb: index does not fit probe word");
      end
   endgenerate

   op_e              op;
   logic [IDX_W-1:0] victim;
   logic             we;
   logic [IDX_W-1:0] wr_idx;
   slot_t            wr_slot, rd_slot, xl_slot;
   logic [ENTRIES-1:0] hit_probe, hit_xl;
   logic             probe_any, xl_any;
   logic [IDX_W-1:0] probe_idx, xl_idx;
   logic [31:0]      paddr_d;
   logic             nc_d;
   xfault_e          fault_d;
   logic             unused_bits;

   assign op     = op_e'(cmd_op);
   assign we     = cmd_valid && (op == OP_WR_IDX || op == OP_WR_RND);
   assign wr_idx = (op == OP_WR_RND) ? victim : cmd_index;

   always_comb begin
      wr_slot      = '0;
      wr_slot.vpn  = cmd_hi[WORD_W-1:PG_OFF_W];
      wr_slot.asid = cmd_hi[ASID_LSB +: ASID_W];
      wr_slot.ppn  = cmd_lo[WORD_W-1:PG_OFF_W];
      wr_slot.nc   = cmd_lo[NC_BIT];
      wr_slot.wen  = cmd_lo[DIRTY_BIT];
      wr_slot.vld  = cmd_lo[VALID_BIT];
      wr_slot.glb  = cmd_lo[GLOBAL_BIT];
   end

   assign unused_bits = ^{cmd_hi[ASID_LSB-1:0], cmd_lo[GLOBAL_BIT-1:0],
                          xl_slot.asid, xl_slot.glb};

   stlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk  (clk),
      .rst_n(rst_n),
      .slot (victim)
   );

   stlb_entries #(.ENTRIES(ENTRIES)) u_entries (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we),
      .wr_idx   (wr_idx),
      .wr_slot  (wr_slot),
      .rd_idx   (cmd_index),
      .rd_slot  (rd_slot),
      .xl_idx   (xl_idx),
      .xl_slot  (xl_slot),
      .key_probe(cmd_hi[WORD_W-1:PG_OFF_W]),
      .key_xl   (xl_vaddr[WORD_W-1:PG_OFF_W]),
      .hit_probe(hit_probe),
      .hit_xl   (hit_xl)
   );

   stlb_prienc #(.N(ENTRIES), .LOW_WINS(PROBE_LOW_WINS)) u_probe_enc (
      .req(hit_probe),
      .any(probe_any),
      .idx(probe_idx)
   );

   stlb_prienc #(.N(ENTRIES), .LOW_WINS(1'b1)) u_xl_enc (
      .req(hit_xl),
      .any(xl_any),
      .idx(xl_idx)
   );

   always_comb begin
      paddr_d = '0;
      nc_d    = 1'b0;
      fault_d = XF_NONE;
      if (xl_vaddr[WORD_W-1]) begin
         paddr_d = xl_vaddr;
      end else if (!xl_any) begin
         fault_d = XF_MISS;
      end else if (!xl_slot.vld) begin
         fault_d = XF_INVALID;
      end else if (xl_write && !xl_slot.wen) begin
         fault_d = XF_MODIFY;
      end else begin
         paddr_d = {xl_slot.ppn, xl_vaddr[PG_OFF_W-1:0]};
         nc_d    = xl_slot.nc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hi     <= '0;
         rsp_lo     <= '0;
         rsp_probe  <= '0;
         xl_done    <= 1'b0;
         xl_paddr   <= '0;
         xl_nocache <= 1'b0;
         xl_fault   <= XF_NONE;
      end else begin
         rsp_valid <= cmd_valid && (op == OP_RD || op == OP_PROBE);
         if (cmd_valid && op == OP_RD) begin
            rsp_hi <= {rd_slot.vpn, rd_slot.asid, {ASID_LSB{1'b0}}};
            rsp_lo <= {rd_slot.ppn, rd_slot.nc, rd_slot.wen, rd_slot.vld,
                       rd_slot.glb, {GLOBAL_BIT{1'b0}}};
         end
         if (cmd_valid && op == OP_PROBE)
            rsp_probe <= probe_any ? {{(WORD_W-IDX_W){1'b0}}, probe_idx} : '1;
         xl_done <= xl_valid;
         if (xl_valid) begin
            xl_paddr   <= paddr_d;
            xl_nocache <= nc_d;
            xl_fault   <= fault_d;
         end
      end
   end

   // R9
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && xl_vaddr[WORD_W-1]) |=>
         (xl_fault == XF_NONE && xl_paddr == $past(xl_vaddr) && !xl_nocache));
   // R8
   load_no_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_write) |=> (xl_fault != XF_MODIFY));
   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_done && xl_fault == XF_MISS) |-> (xl_paddr == '0 && !xl_nocache));
   // R3
   probe_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_PROBE) |=>
         (rsp_valid && (rsp_probe == '1 || rsp_probe < ENTRIES)));
   // R11
   xl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> xl_done);
endmodule

// File: tb/tb_soft_tlb.sv
`timescale 1ns/1ps
module tb_soft_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [5:0]  cmd_index = '0;
   logic [31:0] cmd_hi = '0, cmd_lo = '0;
   logic        rsp_valid;
   logic [31:0] rsp_hi, rsp_lo, rsp_probe;
   logic        xl_valid = 1'b0;
   logic [31:0] xl_vaddr = '0;
   logic        xl_write = 1'b0;
   logic        xl_done;
   logic [31:0] xl_paddr;
   logic        xl_nocache;
   logic [1:0]  xl_fault;

   int checks = 0;
   int errors = 0;
   int edges  = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) if (rst_n) edges <= edges + 1;

   soft_tlb dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
      .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .rsp_valid(rsp_valid), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .rsp_probe(rsp_probe),
      .xl_valid(xl_valid), .xl_vaddr(xl_vaddr), .xl_write(xl_write),
      .xl_done(xl_done), .xl_paddr(xl_paddr), .xl_nocache(xl_nocache), .xl_fault(xl_fault)
   );

   typedef struct packed {
      logic [31:0] va;
      logic        wr;
      logic [1:0]  f;
      logic [31:0] pa;
      logic        nc;
   } xv_t;

   // fault codes: 0 ok, 1 miss, 2 invalid, 3 modify
   localparam xv_t XV [10] = '{
      '{32'h00010ABC, 1'b0, 2'd0, 32'h12345ABC, 1'b0},  // R5 R10
      '{32'h00010004, 1'b1, 2'd0, 32'h12345004, 1'b0},  // R5
      '{32'h00020FFF, 1'b0, 2'd0, 32'h0ABCDFFF, 1'b1},  // R5 R8
      '{32'h00020010, 1'b1, 2'd3, 32'h00000000, 1'b0},  // R8
      '{32'h00030000, 1'b0, 2'd2, 32'h00000000, 1'b0},  // R7
      '{32'h00030000, 1'b1, 2'd2, 32'h00000000, 1'b0},  // R7
      '{32'h00040000, 1'b0, 2'd1, 32'h00000000, 1'b0},  // R6
      '{32'h80000123, 1'b0, 2'd0, 32'h80000123, 1'b0},  // R9
      '{32'hFFFFF001, 1'b1, 2'd0, 32'hFFFFF001, 1'b0},  // R9
      '{32'h7FFFF777, 1'b0, 2'd0, 32'h00001777, 1'b0}   // R5 R10
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [1:0] op, input logic [5:0] idx,
                      input logic [31:0] hi, input logic [31:0] lo);
      cmd_valid = 1'b1; cmd_op = op; cmd_index = idx; cmd_hi = hi; cmd_lo = lo;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic xl(input logic [31:0] va, input logic wr);
      xl_valid = 1'b1; xl_vaddr = va; xl_write = wr;
      @(negedge clk);
      xl_valid = 1'b0;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      int s1, s2;
      repeat (3) @(negedge clk);
      // R1 outputs quiet in reset
      chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R1 xl_done", {31'd0, xl_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset contents, R2 read format
      cmd(2'b10, 6'd7, '0, '0);
      chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      chk("R1 slot7 hi", rsp_hi, 32'h80007000);
      chk("R1 slot7 lo", rsp_lo, 32'h00000000);
      // R3 probe hits parked (invalid) slot
      cmd(2'b11, 6'd0, 32'h80005000, '0);
      chk("R3 probe parked", rsp_probe, 32'd5);

      // setup through indexed writes
      cmd(2'b00, 6'd5,  32'h00010FFF, 32'h123457FF);
      cmd(2'b00, 6'd9,  32'h00020000, 32'h0ABCDA00);
      cmd(2'b00, 6'd12, 32'h00030000, 32'h55555400);
      cmd(2'b00, 6'd63, 32'h7FFFF000, 32'h00001700);

      for (int k = 0; k < 10; k++) begin
         xl(XV[k].va, XV[k].wr);
         chk($sformatf("R11 done v%0d", k), {31'd0, xl_done}, 32'd1);
         chk($sformatf("R5-9 fault v%0d", k), {30'd0, xl_fault}, {30'd0, XV[k].f});
         chk($sformatf("R5 paddr v%0d", k), xl_paddr, XV[k].pa);
         chk($sformatf("R5 nc v%0d", k), {31'd0, xl_nocache}, {31'd0, XV[k].nc});
      end

      // R2 read back masks meaningless bits, keeps tag and global
      cmd(2'b10, 6'd5, '0, '0);
      chk("R2 slot5 hi", rsp_hi, 32'h00010FC0);
      chk("R2 slot5 lo", rsp_lo, 32'h12345700);
      // R3 probe hit ignores low bits; R10 tag ignored
      cmd(2'b11, 6'd0, 32'h00020ABC, '0);
      chk("R3 probe hit", rsp_probe, 32'd9);
      cmd(2'b11, 6'd0, 32'h00010000, '0);
      chk("R10 probe tag", rsp_probe, 32'd5);
      cmd(2'b11, 6'd0, 32'h00099000, '0);
      chk("R3 probe miss", rsp_probe, 32'hFFFFFFFF);

      // R11 write and translate in the same cycle
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_index = 6'd20;
      cmd_hi = 32'h00060000; cmd_lo = 32'h00066600;
      xl_valid = 1'b1; xl_vaddr = 32'h00060010; xl_write = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0; xl_valid = 1'b0;
      chk("R11 same-cycle miss", {30'd0, xl_fault}, 32'd1);
      xl(32'h00060010, 1'b0);
      chk("R11 next-cycle hit", xl_paddr, 32'h00066010);
      chk("R11 next-cycle fault", {30'd0, xl_fault}, 32'd0);

      // R1 R6 parking a slot retires it
      cmd(2'b00, 6'd9, 32'h80009000, 32'h0);
      xl(32'h00020000, 1'b0);
      chk("R6 retired miss", {30'd0, xl_fault}, 32'd1);
      chk("R6 retired paddr", xl_paddr, 32'd0);
      cmd(2'b11, 6'd0, 32'h80009000, '0);
      chk("R3 probe retired", rsp_probe, 32'd9);

      // R4 hardware-chosen slots, back to back
      s1 = (63 - edges) & 63;
      cmd(2'b01, 6'd0, 32'h00050000, 32'h00077600);
      s2 = (63 - edges) & 63;
      cmd(2'b01, 6'd0, 32'h00051000, 32'h00078600);
      cmd(2'b11, 6'd0, 32'h00050000, '0);
      chk("R4 random slot a", rsp_probe, 32'(s1));
      cmd(2'b11, 6'd0, 32'h00051000, '0);
      chk("R4 random slot b", rsp_probe, 32'(s2));

      // R4 wrap from 0 to 63
      while (((63 - edges) & 63) != 0) @(negedge clk);
      cmd(2'b01, 6'd0, 32'h00052000, 32'h00079600);
      cmd(2'b01, 6'd0, 32'h00053000, 32'h0007A600);
      cmd(2'b11, 6'd0, 32'h00052000, '0);
      chk("R4 counter zero", rsp_probe, 32'd0);
      cmd(2'b11, 6'd0, 32'h00053000, '0);
      chk("R4 counter wrap", rsp_probe, 32'd63);
      xl(32'h00053ABC, 1'b1);
      chk("R5 random-installed xlate", xl_paddr, 32'h0007AABC);

      summary();
   end
endmodule